// File: doc/BRIEF.md
# In-Flight Transaction Table Scheduler

This block keeps track of up to 32 outstanding memory transactions and decides when each one may go to a physical resource. Every arriving transaction carries an address, a class and a merge flag. Its address is compared in parallel against the live entries. The outcome picks one of three actions:

- On a miss, the transaction gets a fresh entry.
- On a hit without the merge flag, it gets a fresh entry that waits behind the matching one, which keeps the address ordered.
- On a hit with the merge flag, it takes no entry. The pending entry is flagged to deliver the response.

Entries that are ready compete for issue. Each of the five transaction classes is bound to one of three resources, and a scoreboard holds a resource busy from its issue until the requester pulses a release for it. Selection runs as a two-stage pipeline: the first stage picks an entry with a rotating priority pointer, and the second stage drives it onto its resource port. Completed transactions are removed through the retire input, which also wakes any entry waiting behind them. When every entry is in use, new non-merging transactions are refused through `inReady`.

Top module: `ift_sched`

## Requirements
- R1: After reset, all entries are free, `inReady` is 1, and `allocValid`, `mergeValid` and `issueValid` are 0.
- R2: An accepted transaction with no address match takes the lowest-numbered free entry. `allocValid` is 1 and `allocIdx` shows that index in the cycle after the accepting clock edge. The compare looks only at the newest live entry of each address.
- R3: An accepted transaction that matches a live entry and has `inMerge`=0 gets a new entry that is never issued until the matched entry retires.
- R4: An accepted transaction that matches with `inMerge`=1 takes no entry. In the next cycle `mergeValid` is 1 and `mergeIdx` is the matched index, and `allocValid` stays 0. With `inMerge`=1 and no match, the transaction allocates as in R2.
- R5: A class selects its resource as class modulo 3: classes 0 and 3 use resource 0, classes 1 and 4 use resource 1, and class 2 uses resource 2. The issue shows as bit r of `issueValid`, with `issueIdx` giving the entry.
- R6: A resource is busy from the cycle after its issue until the clock edge at which `resRelease[r]` is 1. No entry is issued to a busy resource.
- R7: An entry that becomes ready at clock edge k, with its resource free, appears on `issueValid` after edge k+1. At most one issue occurs per cycle, and an entry is issued only once.
- R8: Among eligible entries, the one chosen is the first at or after a rotating pointer. The pointer moves to one past each chosen entry and wraps from 31 to 0.
- R9: `retireValid` with `retireIdx` frees the entry only if it has been issued, and it makes ready any entry waiting on it. A retire aimed at an entry not yet issued has no effect.
- R10: While all 32 entries are in use, `inReady` is 0 unless the presented transaction is a merge hit. A retire reopens `inReady` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Arriving transaction present |
| inAddr | input | ADDR_W | Transaction address |
| inClass | input | 3 | Transaction class, 0 to 4 |
| inMerge | input | 1 | Merge on address match instead of serializing |
| inReady | output | 1 | Transaction accepted at this edge if inValid |
| allocValid | output | 1 | An entry was allocated at the previous edge |
| allocIdx | output | 5 | Index of that entry |
| mergeValid | output | 1 | A merge was accepted at the previous edge |
| mergeIdx | output | 5 | Entry merged into |
| issueValid | output | 3 | One-hot issue onto resource port r |
| issueIdx | output | 5 | Entry being issued |
| resRelease | input | 3 | Per-resource release pulse |
| retireValid | input | 1 | Retire request |
| retireIdx | input | 5 | Entry to retire |

## Verification
Allocation and merge reports are due one cycle after the accepting edge. An issue is due one edge after its entry becomes eligible, whether that is through allocation, a retire that wakes it, or a release that frees its resource. `inReady` is combinational on the current inputs. The bench drives at falling edges and reads reports at the first falling edge after the accepting edge. It reads issues one falling edge later, samples `inReady` just after setting the inputs, and confirms silence on `issueValid` over several cycles where an issue is forbidden. The run fills the table to exercise backpressure, and it checks rotation by placing the pointer above a lower free index before two entries compete.

// File: rtl/ift_pkg.sv
package ift_pkg;
  localparam int ENTRIES   = 32;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int CLASSES   = 5;
  localparam int CLS_W     = $clog2(CLASSES);
  localparam int RESOURCES = 3;
  localparam int RES_W     = $clog2(RESOURCES);

  typedef enum logic [1:0] {
    ENT_FREE   = 2'd0,
    ENT_WAIT   = 2'd1,
    ENT_READY  = 2'd2,
    ENT_ISSUED = 2'd3
  } entState_e;

  typedef struct packed {
    logic             alloc;
    logic             allocWait;
    logic [IDX_W-1:0] allocIdx;
    logic [IDX_W-1:0] waitIdx;
    logic [RES_W-1:0] allocRes;
    logic             issue;
    logic [IDX_W-1:0] issueIdx;
    logic             retire;
    logic [IDX_W-1:0] retireIdx;
  } tblStrobe_t;

  function automatic logic [RES_W-1:0] classToRes(input logic [CLS_W-1:0] cls);
    int c;
    c = int'(cls);
    return RES_W'(c % RESOURCES);
  endfunction
endpackage

// File: rtl/ift_rr_pick.sv
module ift_rr_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          pickAny,
  output logic [IW-1:0] pickIdx
);
  // N is a power of two, so the index sum wraps on its own
  always_comb begin
    pickAny = 1'b0;
    pickIdx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[ptr + IW'(k)]) begin
        pickAny = 1'b1;
        pickIdx = ptr + IW'(k);
      end
    end
  end
endmodule

// File: rtl/ift_table.sv
module ift_table
  import ift_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  tblStrobe_t                      strobe,
  input  logic [ADDR_W-1:0]               lookAddr,
  output logic                            hitAny,
  output logic [IDX_W-1:0]                hitIdx,
  output logic                            freeAny,
  output logic [IDX_W-1:0]                freeIdx,
  output logic [ENTRIES-1:0]              readyVec,
  output logic [ENTRIES-1:0]              issuedVec,
  output logic [ENTRIES-1:0][RES_W-1:0]   resOf
);
  entState_e          entState [ENTRIES];
  logic [ADDR_W-1:0]  entAddr  [ENTRIES];
  logic [IDX_W-1:0]   entWait  [ENTRIES];
  logic [RES_W-1:0]   entRes   [ENTRIES];
  logic [ENTRIES-1:0] entTail;
  logic [ENTRIES-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entTail <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entState[i] <= ENT_FREE;
        entAddr[i]  <= '0;
        entWait[i]  <= '0;
        entRes[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.alloc && strobe.allocIdx == IDX_W'(i)) begin
          entState[i] <= strobe.allocWait ? ENT_WAIT : ENT_READY;
          entAddr[i]  <= lookAddr;
          entWait[i]  <= strobe.waitIdx;
          entRes[i]   <= strobe.allocRes;
          entTail[i]  <= 1'b1;
        end else begin
          if (strobe.retire && strobe.retireIdx == IDX_W'(i)) begin
            entState[i] <= ENT_FREE;
            entTail[i]  <= 1'b0;
          end else if (strobe.issue && strobe.issueIdx == IDX_W'(i)) begin
            entState[i] <= ENT_ISSUED;
          end else if (entState[i] == ENT_WAIT && strobe.retire &&
                       entWait[i] == strobe.retireIdx) begin
            entState[i] <= ENT_READY;
          end
          if (strobe.alloc && strobe.allocWait && strobe.waitIdx == IDX_W'(i))
            entTail[i] <= 1'b0;
        end
      end
    end
  end

  // address compare against the newest entry of each chain
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hitVec[i]    = entTail[i] && entState[i] != ENT_FREE && entAddr[i] == lookAddr;
      readyVec[i]  = entState[i] == ENT_READY;
      issuedVec[i] = entState[i] == ENT_ISSUED;
      resOf[i]     = entRes[i];
    end
  end

  always_comb begin
    hitAny  = 1'b0;
    hitIdx  = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (entState[i] == ENT_FREE) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  AST_CAM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec)) else $error("address compare hit several chains"); // R2
  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.alloc |-> entState[strobe.allocIdx] == ENT_FREE) else $error("allocation over live entry"); // R10
  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |-> entState[strobe.issueIdx] == ENT_READY) else $error("issue of entry not ready"); // R3

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entChk
    AST_WAIT_TARGET_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      entState[g] == ENT_WAIT |-> entState[entWait[g]] != ENT_FREE) else $error("waiter lost its target"); // R3
  end
endmodule

// File: rtl/ift_ctrl.sv
module ift_ctrl
  import ift_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inValid,
  input  logic                           inMerge,
  input  logic [CLS_W-1:0]               inClass,
  input  logic                           retireValid,
  input  logic [IDX_W-1:0]               retireIdx,
  input  logic [RESOURCES-1:0]           resRelease,
  input  logic                           hitAny,
  input  logic [IDX_W-1:0]               hitIdx,
  input  logic                           freeAny,
  input  logic [IDX_W-1:0]               freeIdx,
  input  logic [ENTRIES-1:0]             readyVec,
  input  logic [ENTRIES-1:0]             issuedVec,
  input  logic [ENTRIES-1:0][RES_W-1:0]  resOf,
  output tblStrobe_t                     strobe,
  output logic                           inReady,
  output logic                           allocValid,
  output logic [IDX_W-1:0]               allocIdx,
  output logic                           mergeValid,
  output logic [IDX_W-1:0]               mergeIdx,
  output logic [RESOURCES-1:0]           issueValid,
  output logic [IDX_W-1:0]               issueIdx
);
  logic                 retireEff, effHit, doMerge, accept;
  logic [RESOURCES-1:0] resBusy;
  logic [ENTRIES-1:0]   eligible;
  logic                 pickAny;
  logic [IDX_W-1:0]     pickIdx;
  logic [IDX_W-1:0]     rrPtr;
  logic                 s2Valid;
  logic [IDX_W-1:0]     s2Idx;
  logic [RES_W-1:0]     s2Res;

  // a hit on an entry retiring this cycle is treated as a miss
  always_comb begin
    retireEff = retireValid && issuedVec[retireIdx];
    effHit    = hitAny && !(retireEff && hitIdx == retireIdx);
    doMerge   = effHit && inMerge;
    inReady   = doMerge || freeAny;
    accept    = inValid && inReady;
  end

  always_comb begin
    strobe           = '0;
    strobe.alloc     = accept && !doMerge;
    strobe.allocWait = effHit;
    strobe.allocIdx  = freeIdx;
    strobe.waitIdx   = hitIdx;
    strobe.allocRes  = classToRes(inClass);
    strobe.issue     = s2Valid;
    strobe.issueIdx  = s2Idx;
    strobe.retire    = retireEff;
    strobe.retireIdx = retireIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      allocValid <= 1'b0;
      allocIdx   <= '0;
      mergeValid <= 1'b0;
      mergeIdx   <= '0;
    end else begin
      allocValid <= accept && !doMerge;
      allocIdx   <= freeIdx;
      mergeValid <= accept && doMerge;
      mergeIdx   <= hitIdx;
    end
  end

  // stage one: skip the entry held in stage two and the resource it claims
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      eligible[i] = readyVec[i] && !resBusy[resOf[i]] &&
                    !(s2Valid && (s2Idx == IDX_W'(i) || s2Res == resOf[i]));
    end
  end

  ift_rr_pick #(.N(ENTRIES), .IW(IDX_W)) i_pick (
    .req     (eligible),
    .ptr     (rrPtr),
    .pickAny (pickAny),
    .pickIdx (pickIdx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2Valid <= 1'b0;
      s2Idx   <= '0;
      s2Res   <= '0;
      rrPtr   <= '0;
      resBusy <= '0;
    end else begin
      s2Valid <= pickAny;
      s2Idx   <= pickIdx;
      s2Res   <= resOf[pickIdx];
      if (pickAny) rrPtr <= pickIdx + IDX_W'(1);
      for (int r = 0; r < RESOURCES; r++) begin
        resBusy[r] <= (s2Valid && s2Res == RES_W'(r)) || (resBusy[r] && !resRelease[r]);
      end
    end
  end

  for (genvar r = 0; r < RESOURCES; r++) begin : g_port
    assign issueValid[r] = s2Valid && s2Res == RES_W'(r);
    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      issueValid[r] |=> resBusy[r]) else $error("resource not held after issue"); // R6
  end
  assign issueIdx = s2Idx;

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issueValid)) else $error("several issues in one cycle"); // R7
  AST_NO_REPICK: assert property (@(posedge clk) disable iff (!rst_n)
    s2Valid |=> !(s2Valid && s2Idx == $past(s2Idx))) else $error("entry picked twice"); // R7
  AST_ISSUE_RES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    s2Valid |-> !resBusy[s2Res]) else $error("issue to busy resource"); // R6
  AST_PTR_PAST_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    s2Valid |-> rrPtr == s2Idx + IDX_W'(1)) else $error("pointer not past issued entry"); // R8
endmodule

// File: rtl/ift_sched.sv
module ift_sched
  import ift_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic [ADDR_W-1:0]     inAddr,
  input  logic [CLS_W-1:0]      inClass,
  input  logic                  inMerge,
  output logic                  inReady,
  output logic                  allocValid,
  output logic [IDX_W-1:0]      allocIdx,
  output logic                  mergeValid,
  output logic [IDX_W-1:0]      mergeIdx,
  output logic [RESOURCES-1:0]  issueValid,
  output logic [IDX_W-1:0]      issueIdx,
  input  logic [RESOURCES-1:0]  resRelease,
  input  logic                  retireValid,
  input  logic [IDX_W-1:0]      retireIdx
);
  tblStrobe_t                    strobe;
  logic                          hitAny, freeAny;
  logic [IDX_W-1:0]              hitIdx, freeIdx;
  logic [ENTRIES-1:0]            readyVec, issuedVec;
  logic [ENTRIES-1:0][RES_W-1:0] resOf;

  ift_table #(.ADDR_W(ADDR_W)) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .lookAddr  (inAddr),
    .hitAny    (hitAny),
    .hitIdx    (hitIdx),
    .freeAny   (freeAny),
    .freeIdx   (freeIdx),
    .readyVec  (readyVec),
    .issuedVec (issuedVec),
    .resOf     (resOf)
  );

  ift_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .inValid     (inValid),
    .inMerge     (inMerge),
    .inClass     (inClass),
    .retireValid (retireValid),
    .retireIdx   (retireIdx),
    .resRelease  (resRelease),
    .hitAny      (hitAny),
    .hitIdx      (hitIdx),
    .freeAny     (freeAny),
    .freeIdx     (freeIdx),
    .readyVec    (readyVec),
    .issuedVec   (issuedVec),
    .resOf       (resOf),
    .strobe      (strobe),
    .inReady     (inReady),
    .allocValid  (allocValid),
    .allocIdx    (allocIdx),
    .mergeValid  (mergeValid),
    .mergeIdx    (mergeIdx),
    .issueValid  (issueValid),
    .issueIdx    (issueIdx)
  );
endmodule

// File: tb/test_ift_sched.sv
module test_ift_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        inValid;
  logic [15:0] inAddr;
  logic [2:0]  inClass;
  logic        inMerge;
  logic        inReady;
  logic        allocValid;
  logic [4:0]  allocIdx;
  logic        mergeValid;
  logic [4:0]  mergeIdx;
  logic [2:0]  issueValid;
  logic [4:0]  issueIdx;
  logic [2:0]  resRelease;
  logic        retireValid;
  logic [4:0]  retireIdx;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  ift_sched #(.ADDR_W(16)) i_ift_sched (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inAddr(inAddr),
    .inClass(inClass), .inMerge(inMerge), .inReady(inReady),
    .allocValid(allocValid), .allocIdx(allocIdx), .mergeValid(mergeValid),
    .mergeIdx(mergeIdx), .issueValid(issueValid), .issueIdx(issueIdx),
    .resRelease(resRelease), .retireValid(retireValid), .retireIdx(retireIdx)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] a, input logic [2:0] c, input logic m);
    inValid = 1'b1; inAddr = a; inClass = c; inMerge = m;
    tick();
    inValid = 1'b0; inMerge = 1'b0;
  endtask

  task automatic release1(input int r);
    resRelease = 3'(1 << r);
    tick();
    resRelease = '0;
  endtask

  task automatic retire1(input int idx);
    retireValid = 1'b1; retireIdx = 5'(idx);
    tick();
    retireValid = 1'b0;
  endtask

  // expected resource for a class: class modulo 3
  function automatic int portOf(input int cls);
    return 1 << (cls % 3);
  endfunction

  task automatic expectIssue(input string tag, input int cls, input int idx);
    checkEq({tag, " issue port"}, int'(issueValid), portOf(cls));
    checkEq({tag, " issue index"}, int'(issueIdx), idx);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inValid = 1'b0; inAddr = '0; inClass = '0; inMerge = 1'b0;
    resRelease = '0; retireValid = 1'b0; retireIdx = '0;
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    checkEq("R1 inReady", int'(inReady), 1);
    checkEq("R1 allocValid", int'(allocValid), 0);
    checkEq("R1 mergeValid", int'(mergeValid), 0);
    checkEq("R1 issueValid", int'(issueValid), 0);

    // R2 / R7 first allocation and issue timing
    send(16'h0010, 3'd0, 1'b0);
    checkEq("R2 allocValid", int'(allocValid), 1);
    checkEq("R2 allocIdx", int'(allocIdx), 0);
    tick();
    expectIssue("R7 class0", 0, 0);
    tick();
    checkEq("R7 no reissue", int'(issueValid), 0);

    // R6 busy resource blocks, R5 class 3 shares resource 0
    send(16'h0020, 3'd3, 1'b0);
    checkEq("R2 allocIdx second", int'(allocIdx), 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      checkEq("R6 held while busy", int'(issueValid), 0);
    end
    release1(0);
    checkEq("R6 not before pipeline", int'(issueValid), 0);
    tick();
    expectIssue("R5 class3", 3, 1);
    tick();

    send(16'h0030, 3'd4, 1'b0);
    checkEq("R2 allocIdx class4", int'(allocIdx), 2);
    tick();
    expectIssue("R5 class4", 4, 2);
    tick();
    send(16'h0040, 3'd2, 1'b0);
    checkEq("R2 allocIdx class2", int'(allocIdx), 3);
    tick();
    expectIssue("R5 class2", 2, 3);
    tick();

    // R3 serialize behind entry 0
    send(16'h0010, 3'd1, 1'b0);
    checkEq("R3 serialized alloc", int'(allocIdx), 4);
    release1(1);
    tick(); tick();
    checkEq("R3 waiter not issued", int'(issueValid), 0);
    retire1(0);
    tick();
    expectIssue("R9 retire wakes waiter", 1, 4);
    tick();

    // R4 merge hit and merge miss
    send(16'h0010, 3'd1, 1'b1);
    checkEq("R4 mergeValid", int'(mergeValid), 1);
    checkEq("R4 mergeIdx", int'(mergeIdx), 4);
    checkEq("R4 no alloc on merge", int'(allocValid), 0);
    send(16'h0050, 3'd1, 1'b1);
    checkEq("R4 merge miss allocates", int'(allocValid), 1);
    checkEq("R4 merge miss idx", int'(allocIdx), 0);

    // R9 retire of an unissued entry ignored: entry 0 still matches
    retire1(0);
    send(16'h0050, 3'd1, 1'b1);
    checkEq("R9 entry kept", int'(mergeValid), 1);
    checkEq("R9 entry kept idx", int'(mergeIdx), 0);
    release1(1);
    tick();
    expectIssue("R9 still issues", 1, 0);
    tick();

    // R8 rotation: pointer now 1, entries 5..8 on resource 0
    for (int k = 0; k < 4; k++) begin
      send(16'h0060 + 16'(k), 3'd0, 1'b0);
      checkEq("R2 fill idx", int'(allocIdx), 5 + k);
    end
    for (int k = 0; k < 4; k++) begin
      release1(0);
      tick();
      expectIssue("R8 ascending", 0, 5 + k);
      tick();
    end
    retire1(5);
    send(16'h0070, 3'd0, 1'b0);
    checkEq("R2 reuse lowest", int'(allocIdx), 5);
    send(16'h0071, 3'd0, 1'b0);
    checkEq("R2 next free", int'(allocIdx), 9);
    release1(0);
    tick();
    expectIssue("R8 pointer before lower", 0, 9);
    tick();
    release1(0);
    tick();
    expectIssue("R8 wrap", 0, 5);
    tick();

    // R10 fill remaining entries on blocked resource 2
    for (int k = 0; k < 22; k++) begin
      send(16'h0100 + 16'(k), 3'd2, 1'b0);
      checkEq("R10 fill", int'(allocIdx), 10 + k);
    end
    inValid = 1'b1; inAddr = 16'h0200; inClass = 3'd2; inMerge = 1'b0;
    #1 checkEq("R10 full refuses", int'(inReady), 0);
    inAddr = 16'h0100; inMerge = 1'b1;
    #1 checkEq("R10 merge while full", int'(inReady), 1);
    tick();
    inValid = 1'b0; inMerge = 1'b0;
    checkEq("R4 merge full valid", int'(mergeValid), 1);
    checkEq("R4 merge full idx", int'(mergeIdx), 10);
    inValid = 1'b1; inAddr = 16'h0200; inMerge = 1'b1;
    #1 checkEq("R10 merge miss full", int'(inReady), 0);
    inValid = 1'b0; inMerge = 1'b0;
    retire1(2);
    inValid = 1'b1; inAddr = 16'h0200; inClass = 3'd2; inMerge = 1'b0;
    #1 checkEq("R10 reopened", int'(inReady), 1);
    tick();
    inValid = 1'b0;
    checkEq("R10 alloc freed slot", int'(allocIdx), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule